// File: doc/BRIEF.md
# Serial Port Interrupt Status Controller

This block produces the interrupt request for a synchronous serial port that buffers data in a transmit FIFO and a receive FIFO. It watches the occupancy count of each FIFO, a strobe from the receive shifter that marks a finished frame, a strobe that marks a read from the receive FIFO, and a tick that marks one serial bit period. From these it derives four interrupt sources. Two are sticky event flags: receive overrun and receive idle timeout. Two are live level flags: receive FIFO at least half full and transmit FIFO at least half empty.

Software reaches the block through a small register port with a 2-bit address. There is an enable mask, a read-only raw status view, a read-only masked status view, and a write-only clear register. Bit positions are the same in all four: bit 0 overrun, bit 1 timeout, bit 2 receive level, bit 3 transmit level. The masked status is also driven on a port, and a single interrupt line is the OR of its bits. When a frame finishes while the receive FIFO is full, the block withholds the frame's write strobe so the FIFO contents stay unchanged.

The idle timeout is built as a small state machine. Its states are `TO_EMPTY` (the receive FIFO holds nothing), `TO_COUNT` (the FIFO holds data and bit ticks are being counted) and `TO_FIRED` (the flag has been raised and the machine waits for a read). It has these transitions:
- `TO_EMPTY`→`TO_COUNT` when the FIFO becomes non-empty.
- `TO_COUNT`→`TO_FIRED` on the tick that completes the idle window.
- `TO_COUNT`→`TO_COUNT` with the counter restarted on a read.
- `TO_FIRED`→`TO_COUNT` on a read.
- `TO_COUNT`/`TO_FIRED`→`TO_EMPTY` when the FIFO drains.

Top module: `ser_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0, the masked status and `irq` are 0, and with `tx_count` = 0 the raw status reads 4'b1000.
- R2: Raw bit 0 (overrun) sets on the clock edge after `frame_done` is high while `rx_count` equals the FIFO depth (8). It then stays set until it is cleared.
- R3: `rx_accept` is high exactly when `frame_done` is high and `rx_count` is below the depth. A frame that arrives into a full FIFO is therefore discarded.
- R4: Raw bit 1 (timeout) sets on the 32nd `bit_tick` counted while the receive FIFO is non-empty and unread. Counting begins on the cycle after the FIFO becomes non-empty. The bit stays set until it is cleared.
- R5: A receive read (`rx_pop`) or an empty receive FIFO restarts the idle count from zero. Once the flag has fired, no further count starts until the next read.
- R6: Raw bit 2 is 1 whenever `rx_count` >= 4.
- R7: Raw bit 3 is 1 whenever `tx_count` <= 4.
- R8: The mask register is at address 0 and can be read and written. Masked status equals raw status ANDed with the mask, bit by bit.
- R9: `irq` is the OR of the four masked status bits.
- R10: Writing a 1 to bit 0 or bit 1 at address 3 clears the matching sticky flag. Bits 2 and 3 of that write have no effect.
- R11: If a flag's set condition and its clear write occur in the same cycle, the flag is left set.
- R12: Reads return the mask at address 0, the raw status at address 1, the masked status at address 2, and zero at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | 4 | Receive FIFO occupancy |
| tx_count | input | 4 | Transmit FIFO occupancy |
| frame_done | input | 1 | Receive shifter finished a frame |
| rx_pop | input | 1 | Receive FIFO read strobe |
| bit_tick | input | 1 | One serial bit period elapsed |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data (combinational) |
| masked_stat | output | 4 | Masked interrupt status |
| irq | output | 1 | Combined interrupt request |
| rx_accept | output | 1 | Write strobe for the finished frame into the receive FIFO |

## Verification
The following properties are checked on every clock cycle:
- An overrun sets the flag, and the flag holds until cleared.
- A clear write takes the flag down when no set condition is present.
- A clear write loses to a set condition in the same cycle.
- A frame arriving into a full FIFO is never accepted.
- The timeout flag never rises while the FIFO is empty.
- `irq` agrees with the masked status.

The exact length of the idle window and its restart on reads and on draining can only be shown by the bench's timed tick sequences. The same holds for the level thresholds at each FIFO count and for the read map. A behavioural model covers these and also follows a long random phase.

// File: rtl/ser_irq_pkg.sv
package ser_irq_pkg;

    localparam int unsigned NUM_SRC = 4;
    localparam int unsigned BIT_OVR = 0;
    localparam int unsigned BIT_TMO = 1;
    localparam int unsigned BIT_RXL = 2;
    localparam int unsigned BIT_TXL = 3;

    typedef enum logic [1:0] {
        REG_MASK     = 2'd0,
        REG_RAW      = 2'd1,
        REG_MSK_STAT = 2'd2,
        REG_CLEAR    = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        TO_EMPTY = 2'd0,
        TO_COUNT = 2'd1,
        TO_FIRED = 2'd2
    } to_state_e;

endpackage

// File: rtl/ser_irq_timeout.sv
module ser_irq_timeout
    import ser_irq_pkg::*;
#(
    parameter int unsigned TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_empty,
    input  logic pop,
    input  logic tick,
    output logic fire
);
    localparam int unsigned CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    to_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TO_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TO_EMPTY: begin
                cnt_d = '0;
                if (!fifo_empty) state_d = TO_COUNT;
            end
            TO_COUNT: begin
                if (fifo_empty) begin
                    state_d = TO_EMPTY;
                    cnt_d   = '0;
                end else if (pop) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q == LAST) begin
                        state_d = TO_FIRED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            TO_FIRED: begin
                cnt_d = '0;
                if (fifo_empty)  state_d = TO_EMPTY;
                else if (pop)    state_d = TO_COUNT;
            end
            default: begin
                state_d = TO_EMPTY;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        fire = (state_q == TO_COUNT) && !fifo_empty && !pop && tick
               && (cnt_q == LAST);
    end

endmodule

// File: rtl/ser_irq_sticky.sv
module ser_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // set has priority over a coincident clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set | (q & ~clr);
    end
endmodule

// File: rtl/ser_irq_regs.sv
module ser_irq_regs
    import ser_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [1:0]         addr,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] raw,
    output logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] masked,
    output logic [NUM_SRC-1:0] rdata
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       mask <= '0;
        else if (wr && sel == REG_MASK)   mask <= wdata;
    end

    always_comb begin
        masked = raw & mask;
        clr    = (wr && sel == REG_CLEAR) ? wdata : '0;
        unique case (sel)
            REG_MASK:     rdata = mask;
            REG_RAW:      rdata = raw;
            REG_MSK_STAT: rdata = masked;
            REG_CLEAR:    rdata = '0;
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/ser_irq_ctrl.sv
module ser_irq_ctrl
    import ser_irq_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH   = 8,
    parameter int unsigned IDLE_TICKS   = 32,
    localparam int unsigned CNT_W       = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic [CNT_W-1:0]   tx_count,
    input  logic               frame_done,
    input  logic               rx_pop,
    input  logic               bit_tick,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic [NUM_SRC-1:0] masked_stat,
    output logic               irq,
    output logic               rx_accept
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FIFO_DEPTH);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(FIFO_DEPTH / 2);

    logic               rx_full;
    logic               tmo_fire;
    logic [1:0]         sticky_set;
    logic [1:0]         sticky_q;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] raw_stat;

    assign rx_full   = (rx_count == FULL);
    assign rx_accept = frame_done && !rx_full;

    ser_irq_timeout #(.TICKS(IDLE_TICKS)) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (rx_count == '0),
        .pop        (rx_pop),
        .tick       (bit_tick),
        .fire       (tmo_fire)
    );

    assign sticky_set[BIT_OVR] = frame_done && rx_full;
    assign sticky_set[BIT_TMO] = tmo_fire;

    for (genvar g = 0; g < 2; g++) begin : g_sticky
        ser_irq_sticky u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (sticky_set[g]),
            .clr   (clr_vec[g]),
            .q     (sticky_q[g])
        );
    end

    always_comb begin
        raw_stat          = '0;
        raw_stat[BIT_OVR] = sticky_q[BIT_OVR];
        raw_stat[BIT_TMO] = sticky_q[BIT_TMO];
        raw_stat[BIT_RXL] = (rx_count >= HALF);
        raw_stat[BIT_TXL] = (tx_count <= HALF);
    end

    ser_irq_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .raw    (raw_stat),
        .mask   (mask_q),
        .clr    (clr_vec),
        .masked (masked_stat),
        .rdata  (reg_rdata)
    );

    assign irq = |masked_stat;

endmodule

// File: rtl/ser_irq_chk.sv
module ser_irq_chk #(
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned CNT_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] rx_count,
    input logic             frame_done,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [3:0]       reg_wdata,
    input logic [3:0]       raw,
    input logic [3:0]       masked,
    input logic             irq,
    input logic             rx_accept
);
    logic ovr_cond;
    logic clr0;
    assign ovr_cond = frame_done && (rx_count == CNT_W'(FIFO_DEPTH));
    assign clr0     = reg_wr && (reg_addr == 2'd3) && reg_wdata[0];

    assert_ovr_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_cond |=> raw[0]);

    assert_ovr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[0] && !clr0) |=> raw[0]);

    assert_discard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_cond |-> !rx_accept);

    assert_tmo_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw[1]) |-> ($past(rx_count) != '0));

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (masked != 4'd0));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0 && !ovr_cond) |=> !raw[0]);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0 && ovr_cond) |=> raw[0]);
endmodule

bind ser_irq_ctrl ser_irq_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_count   (rx_count),
    .frame_done (frame_done),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .raw        (raw_stat),
    .masked     (masked_stat),
    .irq        (irq),
    .rx_accept  (rx_accept)
);

// File: tb/tb_ser_irq_ctrl.sv
module tb_ser_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rx_count = '0, tx_count = '0;
    logic       frame_done = 1'b0, rx_pop = 1'b0, bit_tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [3:0] reg_wdata = '0;
    logic [3:0] reg_rdata, masked_stat;
    logic       irq, rx_accept;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    // reference model state
    bit m_ovr, m_to, m_active, m_fired;
    int m_idle;
    logic [3:0] m_mask;

    always #4 clk = ~clk;

    ser_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
        .frame_done(frame_done), .rx_pop(rx_pop), .bit_tick(bit_tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .masked_stat(masked_stat), .irq(irq),
        .rx_accept(rx_accept)
    );

    function automatic logic [3:0] m_raw();
        return {tx_count <= 4, rx_count >= 4, m_to, m_ovr};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [3:0] clr;
        bit to_set;
        to_set = 0;
        if (!rst_n) begin
            m_ovr = 0; m_to = 0; m_active = 0; m_fired = 0; m_idle = 0; m_mask = '0;
            return;
        end
        clr = (reg_wr && reg_addr == 2'd3) ? reg_wdata : 4'd0;
        if (rx_count == 0) begin
            m_active = 0; m_fired = 0; m_idle = 0;
        end else if (!m_active) begin
            m_active = 1; m_idle = 0;
        end else if (rx_pop) begin
            m_idle = 0; m_fired = 0;
        end else if (bit_tick && !m_fired) begin
            m_idle++;
            if (m_idle == 32) begin to_set = 1; m_fired = 1; m_idle = 0; end
        end
        m_ovr = (frame_done && rx_count == 8) || (m_ovr && !clr[0]);
        m_to  = to_set || (m_to && !clr[1]);
        if (reg_wr && reg_addr == 2'd0) m_mask = reg_wdata;
    endtask

    task automatic compare_all();
        logic [3:0] r, expd;
        r = m_raw();
        case (reg_addr)
            2'd0: expd = m_mask;
            2'd1: expd = r;
            2'd2: expd = r & m_mask;
            default: expd = 4'd0;
        endcase
        chk("R8 masked", {4'd0, masked_stat}, {4'd0, r & m_mask});
        chk("R9 irq", {7'd0, irq}, {7'd0, |(r & m_mask)});
        chk("R3 accept", {7'd0, rx_accept}, {7'd0, frame_done && rx_count != 8});
        chk("R12 rdata", {4'd0, reg_rdata}, {4'd0, expd});
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_in();
        frame_done = 0; rx_pop = 0; bit_tick = 0; reg_wr = 0;
    endtask

    task automatic read_raw(output logic [3:0] v);
        idle_in(); reg_addr = 2'd1; #1; v = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] v;
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 reset state
        reg_addr = 2'd1; #1; chk("R1 raw", {4'd0, reg_rdata}, 8'h08);
        reg_addr = 2'd0; #1; chk("R1 mask", {4'd0, reg_rdata}, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 masked", {4'd0, masked_stat}, 8'h00);

        // R8 mask write
        reg_wr = 1; reg_addr = 2'd0; reg_wdata = 4'hF; step();
        idle_in(); step();
        chk("R8 mask rd", {4'd0, reg_rdata}, 8'h0F);
        chk("R9 irq on tx level", {7'd0, irq}, 8'h01);

        // R7 / R6 level sweeps
        for (int i = 0; i <= 8; i++) begin
            tx_count = 4'(i); read_raw(v);
            chk("R7 tx level", {7'd0, v[3]}, {7'd0, i <= 4});
            step();
        end
        tx_count = 4'd6;
        for (int i = 0; i <= 8; i++) begin
            rx_count = 4'(i); read_raw(v);
            chk("R6 rx level", {7'd0, v[2]}, {7'd0, i >= 4});
            step();
        end

        // R2 / R3 overrun
        rx_count = 4'd8; frame_done = 1; #1;
        chk("R3 full discard", {7'd0, rx_accept}, 8'h00);
        step();
        read_raw(v); chk("R2 ovr set", {7'd0, v[0]}, 8'h01);
        repeat (5) step();
        read_raw(v); chk("R2 ovr held", {7'd0, v[0]}, 8'h01);
        rx_count = 4'd5; frame_done = 1; #1;
        chk("R3 accept", {7'd0, rx_accept}, 8'h01);
        step();

        // R10 clear: level bits of the clear write ignored
        idle_in(); reg_wr = 1; reg_addr = 2'd3; reg_wdata = 4'b1100; step();
        read_raw(v); chk("R10 level clr ignored", {4'd0, v}, 8'h05);
        reg_wr = 1; reg_addr = 2'd3; reg_wdata = 4'b0001; step();
        read_raw(v); chk("R10 ovr cleared", {7'd0, v[0]}, 8'h00);

        // R11 set wins
        rx_count = 4'd8; frame_done = 1; reg_wr = 1; reg_addr = 2'd3; reg_wdata = 4'b0001;
        step();
        read_raw(v); chk("R11 set wins", {7'd0, v[0]}, 8'h01);
        reg_wr = 1; reg_addr = 2'd3; reg_wdata = 4'b0001; step();

        // R4 timeout window
        idle_in(); rx_count = 4'd0; step();
        rx_count = 4'd2; step();
        for (int i = 0; i < 31; i++) begin bit_tick = 1; step(); end
        read_raw(v); chk("R4 no fire at 31", {7'd0, v[1]}, 8'h00);
        bit_tick = 1; step();
        read_raw(v); chk("R4 fire at 32", {7'd0, v[1]}, 8'h01);
        repeat (3) begin bit_tick = 1; step(); end
        read_raw(v); chk("R4 sticky", {7'd0, v[1]}, 8'h01);
        reg_wr = 1; reg_addr = 2'd3; reg_wdata = 4'b0010; step();
        read_raw(v); chk("R10 tmo cleared", {7'd0, v[1]}, 8'h00);
        // R5 no re-fire without a read
        for (int i = 0; i < 40; i++) begin bit_tick = 1; step(); end
        read_raw(v); chk("R5 no refire", {7'd0, v[1]}, 8'h00);
        // R5 restart on pop
        rx_pop = 1; step(); rx_pop = 0;
        for (int i = 0; i < 20; i++) begin bit_tick = 1; step(); end
        idle_in(); rx_pop = 1; step(); rx_pop = 0;
        for (int i = 0; i < 20; i++) begin bit_tick = 1; step(); end
        read_raw(v); chk("R5 pop restart", {7'd0, v[1]}, 8'h00);
        // R5 restart on empty
        idle_in(); rx_count = 4'd0; step();
        rx_count = 4'd3; step();
        for (int i = 0; i < 31; i++) begin bit_tick = 1; step(); end
        read_raw(v); chk("R5 empty restart", {7'd0, v[1]}, 8'h00);
        bit_tick = 1; step();
        read_raw(v); chk("R5 fire after restart", {7'd0, v[1]}, 8'h01);

        // random phase against the model
        for (int i = 0; i < 3000; i++) begin
            rx_count   = 4'($urandom_range(0, 8));
            if ($urandom_range(0, 3) != 0 && rx_count != 0) rx_count = 4'd2;
            tx_count   = 4'($urandom_range(0, 8));
            frame_done = ($urandom_range(0, 7) == 0);
            rx_pop     = ($urandom_range(0, 40) == 0);
            bit_tick   = ($urandom_range(0, 1) == 0);
            reg_wr     = ($urandom_range(0, 9) == 0);
            reg_addr   = 2'($urandom_range(0, 3));
            reg_wdata  = 4'($urandom_range(0, 15));
            step();
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule